// File: doc/BRIEF.md
# Modem Status Register

This block holds the modem status register of a 16550-compatible serial port. Four active-low modem lines arrive at its pins: carrier detect, ring indicator, data set ready and clear to send. Each passes through a synchronizer and is inverted, and the block shows the resulting levels as four status bits. Beside them it keeps four sticky change flags. Each flag records that its line has moved since the processor last read the register, and a read clears them all.

In loopback mode the status bits stop following the pins. They are cross-wired from four outputs of the modem control register instead, and a status bit that changes when the mode is switched is flagged like any other change. An interrupt output is high whenever any change flag is set. It is meant to drive the modem status source of the port's interrupt logic. Address decoding, the other port registers and the serial datapath are outside this block.

Top module: `mdm_stat_reg`

## Requirements
- R1: `rd_data` is 32 bits wide. Bits 31:8 always read as zero. Bits 7:4 are the status bits, from bit 7 down to bit 4: carrier, ring, ready, clear. Bits 3:0 are the change flags, from bit 3 down to bit 0: carrier delta, ring trailing edge, ready delta, clear delta.
- R2: With `loop_en` low, each status bit is the inverse of its pin. A held pin change appears in the status bit within three clock edges, because of two synchronizer flops and the status register.
- R3: With `loop_en` high, the status bits take their values from the control outputs one edge later: carrier from `ctl_out2`, ring from `ctl_out1`, ready from `ctl_dtr` and clear from `ctl_rts`. The pins then have no effect on `rd_data`.
- R4: The carrier, ready and clear delta flags (bits 3, 1, 0) are set when their status bit changes, whether it rises or falls.
- R5: The ring flag (bit 2) is set only when the ring status bit falls from 1 to 0. A rising ring status leaves it clear.
- R6: A clock edge with `rd_stb` high clears every change flag that has no new event in the same cycle. `rd_data` seen during the strobe cycle holds the values before the clear.
- R7: After synchronous reset the change flags are zero and the status bits equal their current source, with no flag raised by reset itself.
- R8: When a change event and `rd_stb` fall in the same cycle, the read returns the old flag value and the flag is set after the edge, so the event is kept.
- R9: Switching `loop_en` in either direction sets the delta or ring flag of every status bit that changes because of the switch, by the same rules as R4 and R5.
- R10: `irq` is high in exactly the cycles in which at least one change flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_dcd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| pin_ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| pin_dsr_n | input | 1 | Data set ready pin, active low, asynchronous |
| pin_cts_n | input | 1 | Clear to send pin, active low, asynchronous |
| loop_en | input | 1 | Loopback mode enable |
| ctl_out2 | input | 1 | Control register user output 2, the loopback carrier source |
| ctl_out1 | input | 1 | Control register user output 1, the loopback ring source |
| ctl_dtr | input | 1 | Control register terminal-ready bit, the loopback ready source |
| ctl_rts | input | 1 | Control register request-to-send bit, the loopback clear source |
| rd_stb | input | 1 | One-cycle strobe: the register is being read |
| rd_data | output | 32 | Register contents |
| irq | output | 1 | Any change flag set |

## Verification
A status change and a clearing read can land on the same clock edge. That collision decides whether an event is lost. The bench provokes it in loopback mode by dropping `ctl_rts` in the very cycle that `rd_stb` is raised. The scoreboard expects that read to show clean flags and the following read to show the clear-to-send delta. A second overlap is between a mode switch and the flags: toggling `loop_en` while pin and control sources disagree must flag exactly the bits that differ.

// File: rtl/mdm_stat_pkg.sv
package mdm_stat_pkg;
  localparam int LINES   = 4;
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;
  typedef logic [LINES-1:0] line_vec_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  // During reset every stage loads the pin level, so leaving reset causes no false edge.
  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk) stg[k] <= din;
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) stg[k] <= din;
          else     stg[k] <= stg[k-1];
        end
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/mdm_flags.sv
module mdm_flags
  import mdm_stat_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  line_vec_t src,
  input  logic      rd_stb,
  output line_vec_t stat_q,
  output line_vec_t flag_q,
  output logic      irq_q
);
  line_vec_t ev;
  line_vec_t flag_d;

  always_comb begin
    ev = src ^ stat_q;
    // the ring flag reacts to the trailing edge only
    ev[IDX_RI] = stat_q[IDX_RI] & ~src[IDX_RI];
    flag_d = (rd_stb ? '0 : flag_q) | ev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= src;
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= src;
      flag_q <= flag_d;
      irq_q  <= |flag_d;
    end
  end

  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && ev == '0) |=> (flag_q == '0));
  a_r8_event_kept: assert property (@(posedge clk) disable iff (rst)
    (ev != '0) |=> ((flag_q & $past(ev)) == $past(ev)));
  a_r5_ring_fall_only: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q[IDX_RI]) |-> ($past(stat_q[IDX_RI]) && !stat_q[IDX_RI]));
  a_r10_irq_level: assert property (@(posedge clk) disable iff (rst)
    (flag_q != '0) == irq_q);
  a_r7_clean_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flag_q == '0 && !irq_q));
endmodule

// File: rtl/mdm_stat_reg.sv
module mdm_stat_reg
  import mdm_stat_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_dcd_n,
  input  logic              pin_ri_n,
  input  logic              pin_dsr_n,
  input  logic              pin_cts_n,
  input  logic              loop_en,
  input  logic              ctl_out2,
  input  logic              ctl_out1,
  input  logic              ctl_dtr,
  input  logic              ctl_rts,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int RSV_W = DATA_W - 2 * LINES;

  line_vec_t pins_n, pins_sync, loop_src, src, stat_q, flag_q;

  always_comb begin
    pins_n[IDX_DCD]   = pin_dcd_n;
    pins_n[IDX_RI]    = pin_ri_n;
    pins_n[IDX_DSR]   = pin_dsr_n;
    pins_n[IDX_CTS]   = pin_cts_n;
    loop_src[IDX_DCD] = ctl_out2;
    loop_src[IDX_RI]  = ctl_out1;
    loop_src[IDX_DSR] = ctl_dtr;
    loop_src[IDX_CTS] = ctl_rts;
  end

  mdm_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pins_n), .dout(pins_sync)
  );

  assign src = loop_en ? loop_src : ~pins_sync;

  mdm_flags u_flags (
    .clk(clk), .rst(rst), .src(src), .rd_stb(rd_stb),
    .stat_q(stat_q), .flag_q(flag_q), .irq_q(irq)
  );

  assign rd_data = {{RSV_W{1'b0}}, stat_q, flag_q};

  a_r3_loop_map: assert property (@(posedge clk) disable iff (rst)
    $past(loop_en) |-> (rd_data[7:4] == $past({ctl_out2, ctl_out1, ctl_dtr, ctl_rts})));
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-1:8] == '0);
endmodule

// File: tb/mdm_stat_reg_bench.sv
module mdm_stat_reg_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic pin_dcd_n = 1'b1, pin_ri_n = 1'b1, pin_dsr_n = 1'b1, pin_cts_n = 1'b1;
  logic loop_en = 1'b0, ctl_out2 = 1'b0, ctl_out1 = 1'b0, ctl_dtr = 1'b0, ctl_rts = 1'b0;
  logic rd_stb = 1'b0;
  logic [31:0] rd_data;
  logic irq;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mdm_stat_reg u_mdm_stat_reg (
    .clk(clk), .rst(rst), .pin_dcd_n(pin_dcd_n), .pin_ri_n(pin_ri_n),
    .pin_dsr_n(pin_dsr_n), .pin_cts_n(pin_cts_n), .loop_en(loop_en),
    .ctl_out2(ctl_out2), .ctl_out1(ctl_out1), .ctl_dtr(ctl_dtr), .ctl_rts(ctl_rts),
    .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // monitor: each read cycle pops one expected word
  always @(negedge clk) begin
    if (!rst && rd_stb) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read: actual %h expected none", rd_data);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic push(input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic rd(input logic [31:0] e, input string t);
    @(posedge clk); #1;
    push(e, t);
    rd_stb = 1'b1;
    @(posedge clk); #1;
    rd_stb = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_irq(input logic e, input string t);
    @(negedge clk);
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    check_irq(1'b0, "R7 irq after reset");
    rd(32'h00, "R7 R1 reset value");

    pin_cts_n = 1'b0; settle(4);
    check_irq(1'b1, "R10 irq with flag");
    rd(32'h11, "R2 R4 clear rises");
    rd(32'h10, "R6 flags cleared");
    check_irq(1'b0, "R10 irq after clear");

    pin_dcd_n = 1'b0; pin_dsr_n = 1'b0; settle(4);
    rd(32'hBA, "R4 carrier and ready rise");
    rd(32'hB0, "R6 flags cleared");

    pin_ri_n = 1'b0; settle(4);
    rd(32'hF0, "R5 rising ring not flagged");
    pin_ri_n = 1'b1; settle(4);
    rd(32'hB4, "R5 trailing ring flagged");
    rd(32'hB0, "R6 ring flag cleared");

    pin_cts_n = 1'b1; settle(4);
    rd(32'hA1, "R4 clear falls");
    rd(32'hA0, "R6 flags cleared");

    loop_en = 1'b1; settle(2);
    rd(32'h0A, "R9 loop entry flags changes");
    rd(32'h00, "R6 flags cleared");

    ctl_out1 = 1'b1; ctl_rts = 1'b1; settle(2);
    rd(32'h51, "R3 out1 and rts map");
    ctl_out1 = 1'b0; settle(2);
    rd(32'h14, "R3 R5 loop ring trailing");
    ctl_out2 = 1'b1; ctl_dtr = 1'b1; settle(2);
    rd(32'hBA, "R3 out2 and dtr map");
    pin_dcd_n = 1'b1; pin_cts_n = 1'b0; settle(4);
    rd(32'hB0, "R3 pins ignored in loop");

    // R8: event and read in the same cycle
    @(posedge clk); #1;
    ctl_rts = 1'b0;
    push(32'hB0, "R8 read sees old flags");
    rd_stb = 1'b1;
    @(posedge clk); #1;
    rd_stb = 1'b0;
    rd(32'hA1, "R8 colliding event kept");

    loop_en = 1'b0; settle(2);
    rd(32'h39, "R9 loop exit flags changes");
    rd(32'h30, "R6 R2 pin levels back");

    settle(3);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule